// File: doc/BRIEF.md
# Two-Stage Least-Squares / LMS Frequency-Bin Equalizer

This core equalizes a block of frequency-domain samples, eight bins per clock, over a 512-bin block (64 beats per block). It runs in two stages that never overlap, chosen by a stage select input. In the training stage it takes each received bin together with the known training symbol for that bin. It multiplies the received value by the conjugate of the training symbol and by a reciprocal of the training symbol's power, which a companion unit supplies. The result goes into a per-bin register file, either as a fresh value or added to the value already held. In the data stage the same register file holds one complex coefficient per bin. Each received bin is multiplied by its coefficient, and the product is sliced to a pi/2 BPSK or QPSK decision. The coefficient is then moved by an LMS step of the decision error times the conjugate of the received bin, scaled by a power-of-two step size.

Both stages use one pool of eight real multipliers per lane: four in the first pipeline stage and four in the second. Their operands are switched by stage. The register file is read by the equalizer path and written by the update path. A write still pending from the previous beat is forwarded to a read of the same group.

Top module: `lslms_bin_eq`

## Requirements
- R1: `mode_train`=1 selects training and 0 selects data. Any change of `mode_train`, whether or not `in_valid` is high, restarts the group counter at 0. Each valid beat handles group g, and lane i carries bin 8g+i. The group counter advances by one per valid beat and wraps after group 63.
- R2: On the first pass after entering training, bin k's coefficient is written with sat(((tr·xr + ti·xi)·q) >>> 17) for the real part and sat(((tr·xi − ti·xr)·q) >>> 17) for the imaginary part. Here x is the received bin, t is the training symbol and q is the unsigned reciprocal. The same value appears on the output.
- R3: Training passes after the first one in the same stage add that term to the stored coefficient, with saturation. Each entry into training re-arms the first-pass behaviour.
- R4: In the data stage the output is y = sat((c·x) >>> 12) per component, where c is the stored coefficient of that bin.
- R5: The decision per component is +256 when y ≥ 0 and −256 otherwise. With `qpsk`=0 the imaginary decision is 0.
- R6: After each data beat, c becomes sat(c + ((e·conj(x)) >>> `mu_shift`)), where e = decision − y.
- R7: Every coefficient write saturates to the signed 16-bit range [−32768, 32767].
- R8: `out_valid` equals `in_valid` delayed by two clocks. While `out_valid` is low the outputs hold their last value.
- R9: A beat with `in_valid` low changes neither the group counter nor any coefficient.
- R10: A valid beat that reads the group being written by the previous beat uses the newly written coefficient.
- R11: Reset clears `out_valid`, the outputs, all coefficients and the group counter, and arms the first-pass flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_train | input | 1 | 1 = training stage, 0 = data stage |
| qpsk | input | 1 | 1 = QPSK slicing, 0 = BPSK slicing |
| mu_shift | input | 5 | LMS step as a right-shift amount |
| in_valid | input | 1 | Beat carries eight bins |
| rx_re | input | 80 | Received bins, real, 8 × signed 10 bits |
| rx_im | input | 80 | Received bins, imaginary, 8 × signed 10 bits |
| trn_re | input | 80 | Training symbols, real, 8 × signed 10 bits |
| trn_im | input | 80 | Training symbols, imaginary, 8 × signed 10 bits |
| recip | input | 104 | Reciprocal of training power, 8 × unsigned 13 bits |
| out_valid | output | 1 | Output beat valid |
| eq_re | output | 128 | Equalized value (data) or new coefficient (training), real, 8 × signed 16 |
| eq_im | output | 128 | Same, imaginary, 8 × signed 16 |

## Verification
The block can write a group's updated coefficient and read that same group in one cycle. This happens when the stage select toggles on two consecutive valid beats while the counter sits at group 0, because the reselect sends the second beat back to group 0. The bench provokes this by alternating training and data beats back to back and by toggling the stage during an idle beat. Each output is judged against a behavioural model that applies every coefficient update as soon as its beat is taken, so a stale read shows up as a mismatch on the following beat.

// File: rtl/lslms_bin_eq.sv
module lslms_bin_eq #(
  parameter int LANES = 8,
  parameter int BINS  = 512,
  parameter int DW    = 10,
  parameter int CW    = 16,
  parameter int RW    = 13,
  parameter int CF    = 12,
  parameter int RSH   = 17,
  parameter int AMP   = 256,
  parameter int SHW   = 5
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_train,
  input  logic                  qpsk,
  input  logic [SHW-1:0]        mu_shift,
  input  logic                  in_valid,
  input  logic [LANES*DW-1:0]   rx_re,
  input  logic [LANES*DW-1:0]   rx_im,
  input  logic [LANES*DW-1:0]   trn_re,
  input  logic [LANES*DW-1:0]   trn_im,
  input  logic [LANES*RW-1:0]   recip,
  output logic                  out_valid,
  output logic [LANES*CW-1:0]   eq_re,
  output logic [LANES*CW-1:0]   eq_im
);
  localparam int GROUPS = BINS / LANES;
  localparam int AW = $clog2(GROUPS);
  localparam int PW = CW + DW + 1;
  localparam int YW = (DW > RW + 1) ? DW : RW + 1;
  localparam int BW = PW + YW;
  localparam int WW = BW + 4;
  localparam logic signed [WW-1:0] CMAX = WW'((64'sd1 <<< (CW - 1)) - 64'sd1);
  localparam logic signed [WW-1:0] CMIN = -CMAX - 1;
  localparam logic [AW-1:0] LAST = AW'(GROUPS - 1);
  localparam logic signed [CW:0] DPOS = (CW+1)'(AMP);
  localparam logic signed [CW:0] DNEG = -DPOS;

  function automatic logic signed [CW-1:0] sat_c(input logic signed [WW-1:0] v);
    if (v > CMAX) return CMAX[CW-1:0];
    if (v < CMIN) return CMIN[CW-1:0];
    return v[CW-1:0];
  endfunction

  logic mode_q, first_q, reselect, first_use;
  logic [AW-1:0] grp_q, grp_use;

  assign reselect  = mode_train != mode_q;
  assign grp_use   = reselect ? '0 : grp_q;
  assign first_use = reselect | first_q;

  logic s1_valid, s1_train, s1_first, s1_qpsk;
  logic [SHW-1:0] s1_mu;
  logic [AW-1:0] s1_grp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      first_q   <= 1'b1;
      grp_q     <= '0;
      s1_valid  <= 1'b0;
      s1_train  <= 1'b0;
      s1_first  <= 1'b0;
      s1_qpsk   <= 1'b0;
      s1_mu     <= '0;
      s1_grp    <= '0;
      out_valid <= 1'b0;
    end else begin
      mode_q    <= mode_train;
      first_q   <= (in_valid && grp_use == LAST) ? 1'b0 : first_use;
      grp_q     <= in_valid ? ((grp_use == LAST) ? '0 : grp_use + 1'b1) : grp_use;
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
      if (in_valid) begin
        s1_train <= mode_train;
        s1_first <= first_use;
        s1_qpsk  <= qpsk;
        s1_mu    <= mu_shift;
        s1_grp   <= grp_use;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [DW-1:0] xr, xi, tr, ti;
    logic [RW-1:0] rc;
    assign xr = rx_re[l*DW +: DW];
    assign xi = rx_im[l*DW +: DW];
    assign tr = trn_re[l*DW +: DW];
    assign ti = trn_im[l*DW +: DW];
    assign rc = recip[l*RW +: RW];

    logic signed [CW-1:0] rf_r [GROUPS];
    logic signed [CW-1:0] rf_i [GROUPS];
    logic signed [CW-1:0] wr_r, wr_i, cr, ci, ar, ai;
    logic fwd;

    assign fwd = s1_valid && (s1_grp == grp_use);
    assign cr  = fwd ? wr_r : rf_r[grp_use];
    assign ci  = fwd ? wr_i : rf_i[grp_use];
    assign ar  = mode_train ? CW'(tr) : cr;
    assign ai  = mode_train ? CW'(ti) : ci;

    logic signed [CW+DW-1:0] m0, m1, m2, m3;
    assign m0 = (CW+DW)'(ar) * (CW+DW)'(xr);
    assign m1 = (CW+DW)'(ai) * (CW+DW)'(xi);
    assign m2 = (CW+DW)'(ar) * (CW+DW)'(xi);
    assign m3 = (CW+DW)'(ai) * (CW+DW)'(xr);

    logic signed [PW-1:0] pr, pi;
    assign pr = mode_train ? PW'(m0) + PW'(m1) : PW'(m0) - PW'(m1);
    assign pi = mode_train ? PW'(m2) - PW'(m3) : PW'(m2) + PW'(m3);

    logic signed [PW-1:0] s1_pr, s1_pi;
    logic signed [DW-1:0] s1_xr, s1_xi;
    logic signed [CW-1:0] s1_cr, s1_ci;
    logic [RW-1:0] s1_rc;

    logic signed [WW-1:0] eqw_r, eqw_i;
    logic signed [CW-1:0] y_r, y_i;
    assign eqw_r = WW'(s1_pr) >>> CF;
    assign eqw_i = WW'(s1_pi) >>> CF;
    assign y_r = sat_c(eqw_r);
    assign y_i = sat_c(eqw_i);

    logic signed [CW:0] dr, di, er, ei;
    assign dr = y_r[CW-1] ? DNEG : DPOS;
    assign di = !s1_qpsk ? '0 : (y_i[CW-1] ? DNEG : DPOS);
    assign er = dr - (CW+1)'(y_r);
    assign ei = di - (CW+1)'(y_i);

    logic signed [PW-1:0] bx0, bx1, bx2, bx3;
    logic signed [YW-1:0] by0, by1;
    assign bx0 = s1_train ? s1_pr : PW'(er);
    assign bx1 = s1_train ? '0    : PW'(ei);
    assign bx2 = s1_train ? s1_pi : PW'(ei);
    assign bx3 = s1_train ? '0    : PW'(er);
    assign by0 = s1_train ? YW'($signed({1'b0, s1_rc})) : YW'(s1_xr);
    assign by1 = YW'(s1_xi);

    logic signed [BW-1:0] b0, b1, b2, b3;
    assign b0 = BW'(bx0) * BW'(by0);
    assign b1 = BW'(bx1) * BW'(by1);
    assign b2 = BW'(bx2) * BW'(by0);
    assign b3 = BW'(bx3) * BW'(by1);

    logic signed [WW-1:0] qr, qi, dlr, dli, br, bi;
    assign qr  = WW'(b0) + WW'(b1);
    assign qi  = WW'(b2) - WW'(b3);
    assign dlr = s1_train ? (qr >>> RSH) : (qr >>> s1_mu);
    assign dli = s1_train ? (qi >>> RSH) : (qi >>> s1_mu);
    assign br  = (s1_train && s1_first) ? '0 : WW'(s1_cr);
    assign bi  = (s1_train && s1_first) ? '0 : WW'(s1_ci);
    assign wr_r = sat_c(br + dlr);
    assign wr_i = sat_c(bi + dli);

    logic signed [CW-1:0] o_r, o_i;
    assign eq_re[l*CW +: CW] = o_r;
    assign eq_im[l*CW +: CW] = o_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int g = 0; g < GROUPS; g++) begin
          rf_r[g] <= '0;
          rf_i[g] <= '0;
        end
        o_r   <= '0;
        o_i   <= '0;
        s1_pr <= '0;
        s1_pi <= '0;
        s1_xr <= '0;
        s1_xi <= '0;
        s1_cr <= '0;
        s1_ci <= '0;
        s1_rc <= '0;
      end else begin
        if (s1_valid) begin
          rf_r[s1_grp] <= wr_r;
          rf_i[s1_grp] <= wr_i;
          o_r <= s1_train ? wr_r : y_r;
          o_i <= s1_train ? wr_i : y_i;
        end
        if (in_valid) begin
          s1_pr <= pr;
          s1_pi <= pi;
          s1_xr <= xr;
          s1_xi <= xi;
          s1_cr <= cr;
          s1_ci <= ci;
          s1_rc <= rc;
        end
      end
    end
  end
endmodule

module lslms_bin_eq_chk #(
  parameter int LANES = 8,
  parameter int CW    = 16,
  parameter int AW    = 6
)(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic              s1_valid,
  input logic              s1_train,
  input logic [AW-1:0]     s1_grp,
  input logic [LANES*CW-1:0] eq_re,
  input logic [LANES*CW-1:0] eq_im
);
  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  assert_idle_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);
  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(eq_re) && $stable(eq_im)));
  assert_group_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && $past(s1_valid) && (s1_train == $past(s1_train))) |-> (s1_grp == $past(s1_grp) + 1'b1));
  assert_group_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && $past(s1_valid) && (s1_train != $past(s1_train))) |-> (s1_grp == '0));
endmodule

bind lslms_bin_eq lslms_bin_eq_chk #(.LANES(LANES), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .s1_valid(s1_valid), .s1_train(s1_train), .s1_grp(s1_grp),
  .eq_re(eq_re), .eq_im(eq_im));

// File: tb/lslms_bin_eq_tb.sv
module lslms_bin_eq_tb;
  localparam int CLK_P = 10;
  localparam int LANES = 8, BINS = 512, DW = 10, CW = 16, RW = 13, CF = 12, RSH = 17, AMP = 256;
  localparam int GROUPS = BINS / LANES;

  logic clk = 0, rst_n = 0;
  logic mode_train = 0, qpsk = 1, in_valid = 0;
  logic [4:0] mu_shift = 5'd5;
  logic [LANES*DW-1:0] rx_re = '0, rx_im = '0, trn_re = '0, trn_im = '0;
  logic [LANES*RW-1:0] recip = '0;
  logic out_valid;
  logic [LANES*CW-1:0] eq_re, eq_im;

  lslms_bin_eq u_dut (.clk(clk), .rst_n(rst_n), .mode_train(mode_train), .qpsk(qpsk),
    .mu_shift(mu_shift), .in_valid(in_valid), .rx_re(rx_re), .rx_im(rx_im),
    .trn_re(trn_re), .trn_im(trn_im), .recip(recip), .out_valid(out_valid),
    .eq_re(eq_re), .eq_im(eq_im));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R11";

  function automatic longint sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  longint mc_r [BINS];
  longint mc_i [BINS];
  bit m_mode = 0, m_first = 1;
  int m_addr = 0;
  bit n_v, e1_v, x_v;
  longint n_r [LANES], n_i [LANES], e1_r [LANES], e1_i [LANES], x_r [LANES], x_i [LANES];
  bit sel, fu;
  int au, b;
  longint xr, xi, tr, ti, rc, pr, pi, yr, yi, dcr, dci, er, ei;

  initial for (int k = 0; k < BINS; k++) begin mc_r[k] = 0; mc_i[k] = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < BINS; k++) begin mc_r[k] = 0; mc_i[k] = 0; end
      m_mode = 0; m_first = 1; m_addr = 0; e1_v = 0; x_v = 0;
      for (int l = 0; l < LANES; l++) begin e1_r[l] = 0; e1_i[l] = 0; x_r[l] = 0; x_i[l] = 0; end
    end else begin
      sel = (mode_train != m_mode);
      au = sel ? 0 : m_addr;
      fu = sel ? 1'b1 : m_first;
      n_v = in_valid;
      if (in_valid) begin
        for (int l = 0; l < LANES; l++) begin
          b  = au * LANES + l;
          xr = longint'($signed(rx_re[l*DW +: DW]));
          xi = longint'($signed(rx_im[l*DW +: DW]));
          tr = longint'($signed(trn_re[l*DW +: DW]));
          ti = longint'($signed(trn_im[l*DW +: DW]));
          rc = longint'(recip[l*RW +: RW]);
          if (mode_train) begin
            pr = ((tr * xr + ti * xi) * rc) >>> RSH;
            pi = ((tr * xi - ti * xr) * rc) >>> RSH;
            mc_r[b] = fu ? sat(pr) : sat(mc_r[b] + pr);
            mc_i[b] = fu ? sat(pi) : sat(mc_i[b] + pi);
            n_r[l] = mc_r[b]; n_i[l] = mc_i[b];
          end else begin
            yr = sat((mc_r[b] * xr - mc_i[b] * xi) >>> CF);
            yi = sat((mc_r[b] * xi + mc_i[b] * xr) >>> CF);
            dcr = (yr >= 0) ? AMP : -AMP;
            dci = qpsk ? ((yi >= 0) ? AMP : -AMP) : 0;
            er = dcr - yr; ei = dci - yi;
            mc_r[b] = sat(mc_r[b] + ((er * xr + ei * xi) >>> mu_shift));
            mc_i[b] = sat(mc_i[b] + ((ei * xr - er * xi) >>> mu_shift));
            n_r[l] = yr; n_i[l] = yi;
          end
        end
      end
      m_first = (in_valid && au == GROUPS - 1) ? 1'b0 : fu;
      m_addr  = in_valid ? ((au + 1) % GROUPS) : au;
      m_mode  = mode_train;
      x_v = e1_v;
      if (e1_v) for (int l = 0; l < LANES; l++) begin x_r[l] = e1_r[l]; x_i[l] = e1_i[l]; end
      e1_v = n_v;
      if (n_v) for (int l = 0; l < LANES; l++) begin e1_r[l] = n_r[l]; e1_i[l] = n_i[l]; end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      checks++;
      if (out_valid !== 1'b0 || eq_re !== '0 || eq_im !== '0) begin
        errors++;
        $display("FAIL R11 reset state: out_valid %b eq_re %h eq_im %h expected 0", out_valid, eq_re, eq_im);
      end
    end else begin
      checks++;
      if (out_valid !== x_v) begin
        errors++;
        $display("FAIL R8 out_valid act %b exp %b at cycle %0d", out_valid, x_v, cyc);
      end
      checks++;
      for (int l = 0; l < LANES; l++) begin
        longint ar, ai;
        ar = longint'($signed(eq_re[l*CW +: CW]));
        ai = longint'($signed(eq_im[l*CW +: CW]));
        if (ar != x_r[l] || ai != x_i[l]) begin
          errors++;
          $display("FAIL %s lane %0d act (%0d,%0d) exp (%0d,%0d) valid %b cycle %0d",
                   x_v ? tag : "R8", l, ar, ai, x_r[l], x_i[l], x_v, cyc);
          break;
        end
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 60000);
    errors++;
    $display("FAIL watchdog expired act cycle %0d exp completion", cyc);
    summary();
  end

  // kind 0: random bins; kind 1: bins aligned with training (positive growth), opposed on odd lanes
  task automatic beat(input bit trn, input bit v, input int kind, input int rbase);
    @(negedge clk);
    mode_train = trn;
    in_valid = v;
    for (int l = 0; l < LANES; l++) begin
      int sr, si, a, c;
      sr = $urandom_range(0, 1) ? 1 : -1;
      si = $urandom_range(0, 1) ? 1 : -1;
      trn_re[l*DW +: DW] = DW'(sr * 256);
      trn_im[l*DW +: DW] = DW'(si * 256);
      if (kind == 1) begin
        a = (l % 2 == 0) ? sr * 511 : -sr * 511;
        c = (l % 2 == 0) ? si * 511 : -si * 511;
      end else begin
        a = int'($urandom_range(0, 600)) - 300;
        c = int'($urandom_range(0, 600)) - 300;
      end
      rx_re[l*DW +: DW] = DW'(a);
      rx_im[l*DW +: DW] = DW'(c);
      recip[l*RW +: RW] = RW'(rbase + ((kind == 1) ? 0 : int'($urandom_range(0, 255))));
    end
  endtask

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R11";                       // coefficients cleared: data output is zero
    repeat (2) beat(0, 1, 0, 4096);
    tag = "R2";
    repeat (GROUPS) beat(1, 1, 0, 4096);
    tag = "R3";
    repeat (GROUPS) beat(1, 1, 0, 4096);
    tag = "R9";
    for (int k = 0; k < 16; k++) beat(1, k % 2 == 0, 0, 4096);
    tag = "R4";
    mu_shift = 5'd5;
    repeat (2 * GROUPS) beat(0, 1, 0, 4096);
    tag = "R6";
    mu_shift = 5'd3;
    repeat (GROUPS) beat(0, 1, 0, 4096);
    tag = "R5";
    qpsk = 0;
    repeat (GROUPS) beat(0, 1, 0, 4096);
    qpsk = 1;
    tag = "R1";
    repeat (5) beat(1, 1, 0, 4096);
    beat(0, 0, 0, 4096);               // reselect during an idle beat
    repeat (5) beat(0, 1, 0, 4096);
    tag = "R10";
    beat(1, 1, 0, 4096);
    beat(0, 1, 0, 4096);
    beat(1, 1, 0, 4096);
    beat(0, 1, 0, 4096);
    beat(0, 1, 0, 4096);
    tag = "R7";
    repeat (3 * GROUPS) beat(1, 1, 1, 8191);
    mu_shift = 5'd0;
    repeat (2 * GROUPS) beat(0, 1, 0, 4096);
    beat(0, 0, 0, 4096);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule